// File: doc/BRIEF.md
# Register Type-Tag Tracker and Unit Dispatcher

This block records one type bit for each architectural register. A set bit marks a floating-point value. A clear bit marks integer, address or any other non-floating data. Because of these bits, a single opcode can stand for both the integer and the floating-point form of an operation, and the execution unit is picked at decode time from the bits of the source registers. The bits are kept apart from the data register file. They change on write-back events: integer loads, floating loads, arithmetic results, and the two tag-only moves (OR with itself, OR with zero).

In the decode cycle the block reads the tags of both sources and produces several outputs: an issue strobe, the unit select, the tag that the destination will receive, and per-operand conversion requests. When the two source tags disagree, a 2-bit policy input chooses the response. The choices are to raise a type-mismatch exception, to follow source 1 with conversion of operand 2, to force floating point and convert the integer operand, or to follow source 1 with no conversion. Save and restore sequences, including interrupt context switches, read all tags as one word and load them back through a restore port.

Top module: `regtag_dispatch`

## Requirements
- R1: Reset clears every tag, so the snapshot `ctx_tags` reads all zero after reset.
- R2: On the clock edge, `wb_kind` 3'd1 (integer load) writes tag 0 to register `wb_rd`, and `wb_kind` 3'd2 (floating load) writes tag 1 to it.
- R3: `wb_kind` 3'd3 (arithmetic result) writes `wb_res_tag` into the tag of `wb_rd`.
- R4: `wb_kind` 3'd4 (OR with itself) sets the tag of `wb_rd` and 3'd5 (OR with zero) clears it. The codes 3'd0, 3'd6 and 3'd7 write no tag.
- R5: For a valid instruction with `dec_cls` 2'b01 (shared two-source op: add, subtract, multiply, divide, max, min, compare) and equal source tags, the block raises `issue`. Both `route_fp` and `dst_tag` equal that tag. No conversion is requested and there is no exception.
- R6: With differing source tags and `mix_policy` 2'b00, `mismatch_exc` is 1 and `issue`, `route_fp`, `dst_tag` and both conversion flags are 0.
- R7: With differing source tags and `mix_policy` 2'b01, the instruction issues with `route_fp` and `dst_tag` equal to the source 1 tag, `cvt_src2` is 1 and `cvt_src1` is 0.
- R8: With differing source tags and `mix_policy` 2'b10, the instruction issues with `route_fp` and `dst_tag` set to 1, and the conversion flag is raised only on the operand whose tag is 0.
- R9: With differing source tags and `mix_policy` 2'b11, the instruction issues with `route_fp` and `dst_tag` equal to the source 1 tag and no conversion.
- R10: `dec_cls` 2'b10 (one-source shared op: abs, or a floating-only/integer-only opcode pair) routes on the source 1 tag alone, gives that tag to the destination, and never raises an exception. `dec_cls` 2'b00 or 2'b11, or `dec_valid` low, drives every decode output to 0.
- R11: A tag write or restore in the same cycle as a decode is visible to that decode's source reads.
- R12: `ctx_tags` shows the stored tags (bit i is register i). `ctx_restore_en` loads `ctx_restore_word` at the clock edge. A write-back in the same cycle takes precedence for its own register.
- R13: With `ZERO_REG` set, register 0 always reads tag 0 and ignores write-backs and restores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_kind | input | 3 | Write-back event code |
| wb_rd | input | 5 | Write-back destination register |
| wb_res_tag | input | 1 | Result tag for arithmetic write-back |
| ctx_restore_en | input | 1 | Load all tags from the restore word |
| ctx_restore_word | input | 32 | Tag word from a saved context |
| ctx_tags | output | 32 | Tag snapshot for context save |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_cls | input | 2 | Instruction class |
| dec_src1 | input | 5 | Source 1 register |
| dec_src2 | input | 5 | Source 2 register |
| mix_policy | input | 2 | Response to differing source tags |
| issue | output | 1 | Instruction dispatched to a unit |
| route_fp | output | 1 | 1 = floating-point unit, 0 = integer unit |
| dst_tag | output | 1 | Tag the destination will receive |
| cvt_src1 | output | 1 | Convert operand 1 before the operation |
| cvt_src2 | output | 1 | Convert operand 2 before the operation |
| mismatch_exc | output | 1 | Type-mismatch exception |

## Verification
The hardest case to reach is a decode whose source tags are changed in the same cycle by a write-back, a restore, or both. This matters most when it turns a matching pair into a mismatch under each policy, because the outputs then depend on the forwarded view and not on the stored tags. Directed steps aim a floating load at a source register being decoded in the same cycle, and aim a restore word at one. Weighted random cycles then combine random write-backs, occasional restores and random policies on a small register window, so that collisions between the write target and the sources occur often.

// File: rtl/regtag_dispatch.sv
module regtag_dispatch #(
  parameter int NREG     = 32,
  parameter bit ZERO_REG = 1'b1,
  localparam int AW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      wb_kind,
  input  logic [AW-1:0]   wb_rd,
  input  logic            wb_res_tag,
  input  logic            ctx_restore_en,
  input  logic [NREG-1:0] ctx_restore_word,
  output logic [NREG-1:0] ctx_tags,
  input  logic            dec_valid,
  input  logic [1:0]      dec_cls,
  input  logic [AW-1:0]   dec_src1,
  input  logic [AW-1:0]   dec_src2,
  input  logic [1:0]      mix_policy,
  output logic            issue,
  output logic            route_fp,
  output logic            dst_tag,
  output logic            cvt_src1,
  output logic            cvt_src2,
  output logic            mismatch_exc
);

  logic [NREG-1:0] tags_q, tags_d;
  logic            wr_en, wr_val;
  logic            t1, t2;

  always_comb begin
    wr_en  = 1'b1;
    wr_val = 1'b0;
    case (wb_kind)
      3'd1:    wr_val = 1'b0;
      3'd2:    wr_val = 1'b1;
      3'd3:    wr_val = wb_res_tag;
      3'd4:    wr_val = 1'b1;
      3'd5:    wr_val = 1'b0;
      default: wr_en  = 1'b0;
    endcase
  end

  always_comb begin
    tags_d = ctx_restore_en ? ctx_restore_word : tags_q;
    if (wr_en) tags_d[wb_rd] = wr_val;
    if (ZERO_REG) tags_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tags_q <= '0;
    else        tags_q <= tags_d;
  end

  assign ctx_tags = tags_q;
  assign t1 = tags_d[dec_src1];
  assign t2 = tags_d[dec_src2];

  wire two_src = dec_valid && (dec_cls == 2'b01);
  wire one_src = dec_valid && (dec_cls == 2'b10);
  wire differ  = two_src && (t1 != t2);

  always_comb begin
    issue        = 1'b0;
    route_fp     = 1'b0;
    dst_tag      = 1'b0;
    cvt_src1     = 1'b0;
    cvt_src2     = 1'b0;
    mismatch_exc = 1'b0;
    if (one_src || (two_src && !differ)) begin
      issue    = 1'b1;
      route_fp = t1;
      dst_tag  = t1;
    end else if (differ) begin
      case (mix_policy)
        2'b00: mismatch_exc = 1'b1;
        2'b01: begin
          issue    = 1'b1;
          route_fp = t1;
          dst_tag  = t1;
          cvt_src2 = 1'b1;
        end
        2'b10: begin
          issue    = 1'b1;
          route_fp = 1'b1;
          dst_tag  = 1'b1;
          cvt_src1 = ~t1;
          cvt_src2 = ~t2;
        end
        default: begin
          issue    = 1'b1;
          route_fp = t1;
          dst_tag  = t1;
        end
      endcase
    end
  end

endmodule

// File: rtl/regtag_dispatch_chk.sv
module regtag_dispatch_chk #(
  parameter int NREG     = 32,
  parameter bit ZERO_REG = 1'b1,
  localparam int AW      = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      wb_kind,
  input logic [AW-1:0]   wb_rd,
  input logic            wb_res_tag,
  input logic            ctx_restore_en,
  input logic [NREG-1:0] ctx_restore_word,
  input logic [NREG-1:0] ctx_tags,
  input logic            dec_valid,
  input logic [1:0]      dec_cls,
  input logic [AW-1:0]   dec_src1,
  input logic [AW-1:0]   dec_src2,
  input logic [1:0]      mix_policy,
  input logic            issue,
  input logic            route_fp,
  input logic            dst_tag,
  input logic            cvt_src1,
  input logic            cvt_src2,
  input logic            mismatch_exc
);

  localparam logic [NREG-1:0] ZMASK = ZERO_REG ? ~{{(NREG-1){1'b0}}, 1'b1} : {NREG{1'b1}};

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ctx_tags == '0);

  a_r2_fp_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_kind == 3'd2 && (wb_rd != '0 || !ZERO_REG)) |=> ctx_tags[$past(wb_rd)]);

  a_r4_or_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_kind == 3'd5) |=> !ctx_tags[$past(wb_rd)]);

  a_r5_plain_issue_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !cvt_src1 && !cvt_src2) |-> route_fp == dst_tag);

  a_r6_exc_only_policy0: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_exc |-> (dec_valid && dec_cls == 2'b01 && mix_policy == 2'b00 && !issue));

  a_r8_single_conversion: assert property (@(posedge clk) disable iff (!rst_n)
    !(cvt_src1 && cvt_src2));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid || dec_cls == 2'b00 || dec_cls == 2'b11) |-> !(issue || mismatch_exc || cvt_src1 || cvt_src2));

  a_r12_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_restore_en && (wb_kind == 3'd0 || wb_kind > 3'd5)) |=> ctx_tags == ($past(ctx_restore_word) & ZMASK));

  a_r13_zero_reg_tag: assert property (@(posedge clk) disable iff (!rst_n)
    !ZERO_REG || !ctx_tags[0]);

endmodule

bind regtag_dispatch regtag_dispatch_chk #(.NREG(NREG), .ZERO_REG(ZERO_REG)) u_chk (.*);

// File: tb/test_regtag_dispatch.sv
`timescale 1ns/1ps
module test_regtag_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wb_kind = '0;
  logic [4:0]  wb_rd = '0;
  logic        wb_res_tag = 1'b0;
  logic        ctx_restore_en = 1'b0;
  logic [31:0] ctx_restore_word = '0;
  logic [31:0] ctx_tags;
  logic        dec_valid = 1'b0;
  logic [1:0]  dec_cls = '0;
  logic [4:0]  dec_src1 = '0, dec_src2 = '0;
  logic [1:0]  mix_policy = '0;
  logic        issue, route_fp, dst_tag, cvt_src1, cvt_src2, mismatch_exc;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  regtag_dispatch i_regtag_dispatch (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt_tags(input logic [31:0] cur);
    logic [31:0] n = ctx_restore_en ? ctx_restore_word : cur;
    case (wb_kind)
      3'd1: n[wb_rd] = 1'b0;
      3'd2: n[wb_rd] = 1'b1;
      3'd3: n[wb_rd] = wb_res_tag;
      3'd4: n[wb_rd] = 1'b1;
      3'd5: n[wb_rd] = 1'b0;
      default: ;
    endcase
    n[0] = 1'b0;
    return n;
  endfunction

  // {issue, route_fp, dst_tag, cvt_src1, cvt_src2, mismatch_exc}
  function automatic logic [5:0] exp_out(input logic [31:0] v, output string req);
    logic a = v[dec_src1];
    logic b = v[dec_src2];
    req = "R10";
    if (!dec_valid || dec_cls == 2'b00 || dec_cls == 2'b11) return 6'b0;
    if (dec_cls == 2'b10) return {1'b1, a, a, 3'b000};
    if (a == b) begin req = "R5"; return {1'b1, a, a, 3'b000}; end
    case (mix_policy)
      2'b00: begin req = "R6"; return 6'b000001; end
      2'b01: begin req = "R7"; return {1'b1, a, a, 3'b010}; end
      2'b10: begin req = "R8"; return {3'b111, ~a, ~b, 1'b0}; end
      default: begin req = "R9"; return {1'b1, a, a, 3'b000}; end
    endcase
  endfunction

  task automatic step(input string lbl, input logic [2:0] k, input logic [4:0] rd, input logic rt,
                      input logic ren, input logic [31:0] rw, input logic v, input logic [1:0] cls,
                      input logic [4:0] s1, input logic [4:0] s2, input logic [1:0] pol);
    string rq;
    logic [31:0] n;
    logic [5:0] e;
    @(negedge clk);
    wb_kind = k; wb_rd = rd; wb_res_tag = rt; ctx_restore_en = ren; ctx_restore_word = rw;
    dec_valid = v; dec_cls = cls; dec_src1 = s1; dec_src2 = s2; mix_policy = pol;
    #1;
    n = nxt_tags(model);
    e = exp_out(n, rq);
    chk({lbl, " R12 snapshot"}, ctx_tags, model);
    chk({lbl, " ", rq, " decode"}, {26'b0, issue, route_fp, dst_tag, cvt_src1, cvt_src2, mismatch_exc}, {26'b0, e});
    @(posedge clk);
    model = n;
  endtask

  task automatic idle();
    step("idle", 3'd0, 5'd0, 1'b0, 1'b0, '0, 1'b0, 2'b00, 5'd0, 5'd0, 2'b00);
  endtask

  initial begin
    #150000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 chk("R1 reset snapshot", ctx_tags, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    idle();
    chk("R1 after release", ctx_tags, 32'h0);

    step("R2 fp load", 3'd2, 5'd5, 1'b0, 1'b0, '0, 1'b0, 2'b00, 5'd0, 5'd0, 2'b00);
    step("R2 int load", 3'd1, 5'd6, 1'b0, 1'b0, '0, 1'b0, 2'b00, 5'd0, 5'd0, 2'b00);
    #1 chk("R2 tags r5/r6", {30'b0, ctx_tags[6], ctx_tags[5]}, 32'h1);
    step("R3 arith tag", 3'd3, 5'd9, 1'b1, 1'b0, '0, 1'b0, 2'b00, 5'd0, 5'd0, 2'b00);
    #1 chk("R3 tag r9", {31'b0, ctx_tags[9]}, 32'h1);
    step("R4 or-self", 3'd4, 5'd10, 1'b0, 1'b0, '0, 1'b0, 2'b00, 5'd0, 5'd0, 2'b00);
    step("R4 or-zero", 3'd5, 5'd5, 1'b0, 1'b0, '0, 1'b0, 2'b00, 5'd0, 5'd0, 2'b00);
    step("R4 no-write code", 3'd6, 5'd9, 1'b0, 1'b0, '0, 1'b0, 2'b00, 5'd0, 5'd0, 2'b00);
    #1 chk("R4 tags r10/r5/r9", {29'b0, ctx_tags[10], ctx_tags[5], ctx_tags[9]}, 32'h5);

    step("R5 fp pair", 3'd0, 5'd0, 1'b0, 1'b0, '0, 1'b1, 2'b01, 5'd9, 5'd10, 2'b00);
    step("R5 int pair", 3'd0, 5'd0, 1'b0, 1'b0, '0, 1'b1, 2'b01, 5'd5, 5'd6, 2'b00);
    for (int p = 0; p < 4; p++) begin
      step("R6-9 fp/int", 3'd0, 5'd0, 1'b0, 1'b0, '0, 1'b1, 2'b01, 5'd9, 5'd6, p[1:0]);
      step("R6-9 int/fp", 3'd0, 5'd0, 1'b0, 1'b0, '0, 1'b1, 2'b01, 5'd6, 5'd9, p[1:0]);
    end
    step("R10 unary fp", 3'd0, 5'd0, 1'b0, 1'b0, '0, 1'b1, 2'b10, 5'd9, 5'd6, 2'b00);
    step("R10 class3", 3'd0, 5'd0, 1'b0, 1'b0, '0, 1'b1, 2'b11, 5'd9, 5'd6, 2'b00);
    step("R11 forward load", 3'd2, 5'd6, 1'b0, 1'b0, '0, 1'b1, 2'b01, 5'd9, 5'd6, 2'b00);
    step("R11 forward restore", 3'd0, 5'd0, 1'b0, 1'b1, 32'h0000_0100, 1'b1, 2'b01, 5'd8, 5'd9, 2'b00);
    step("R12 restore+wb", 3'd4, 5'd3, 1'b0, 1'b1, 32'hA5A5_0F0F, 1'b0, 2'b00, 5'd0, 5'd0, 2'b00);
    #1 chk("R12 restored word", ctx_tags, 32'hA5A5_0F0E);
    step("R13 zero reg write", 3'd2, 5'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 2'b01, 5'd0, 5'd1, 2'b10);
    #1 chk("R13 zero reg tag", {31'b0, ctx_tags[0]}, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] k = 3'($urandom_range(0, 7));
      logic ren = ($urandom_range(0, 15) == 0);
      step("rand", k, 5'($urandom_range(0, 5)), 1'($urandom), ren, $urandom,
           ($urandom_range(0, 7) != 0), 2'($urandom), 5'($urandom_range(0, 5)),
           5'($urandom_range(0, 5)), 2'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule